// File: doc/BRIEF.md
# Static Crosspoint Router for a Neural-Core Mesh

This block is one node of a two-dimensional mesh that links neural cores. It has five 8-bit ports: four toward neighbouring nodes and one toward the attached core. The routes are static. Each output port takes its data from one input port chosen by a configuration entry. That entry is written once over a small setup port. No addresses are decoded and no arbitration is done while data flows. Neuron layers send their outputs on every iteration, so the traffic pattern is fixed in advance. A fixed route table is therefore enough.

Each output has its own register, so one hop costs exactly one clock. The local output may take the local input. This loops a core's results straight back into the same core, which serves recurrent layers and several layers packed into one core. Two or more outputs may name the same input, and that input is then copied to all of them.

Top module: `mesh_route_switch`

## Requirements
- R1: Each port carries an 8-bit word. In both `in_bus` and `out_bus`, port p sits at bits [8p+7:8p], with north=0, south=1, east=2, west=3 and local=4.
- R2: When an output's entry is usable, the output presents the selected input word exactly one clock after that word was applied, and its `out_vld` bit is high.
- R3: A configuration write uses `cfg_we`=1, a target output in `cfg_port`, and `cfg_val`, where bit 3 is the enable and bits 2:0 are the source port. The entry changes at the sampling edge, and the output registered at the following edge uses the new entry.
- R4: The local output may select the local input, so a core's own word returns to it after one cycle.
- R5: Several outputs may select the same input, and each of them then carries that input's word.
- R6: An output whose entry has its enable bit clear drives all-zero data with `out_vld` low.
- R7: An entry with the enable bit set but a source code of 5, 6 or 7 behaves like a disabled entry (zero data, `out_vld` low).
- R8: A write whose `cfg_port` is 5, 6 or 7 changes no entry.
- R9: Synchronous reset disables every entry and clears every output register, so all outputs read zero with `out_vld` low.
- R10: Without writes, every entry keeps its value indefinitely, and the routes do not depend on the data that flows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Output port whose entry is written |
| cfg_val | input | 4 | Entry value: bit 3 enable, bits 2:0 source port |
| in_bus | input | 40 | Five packed 8-bit input words |
| out_bus | output | 40 | Five packed 8-bit registered output words |
| out_vld | output | 5 | Per-output valid strobe |

## Verification
A corrupted route entry shows up at the ports on the first clock edge after it goes wrong. The affected output either carries some other port's word, turns zero, or raises or drops its valid strobe. The bench sends distinct random words on all five inputs every cycle, so a wrong source is almost always told apart from the right one within one cycle. Writes that are stray, late or misdecoded show as an output that follows the old source, or the wrong output switching, on the second edge after the write.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
    localparam int LINK_W = 8;
    localparam int NPORTS = 5;
    localparam int SEL_W  = 3;
    localparam int CFG_W  = SEL_W + 1;
    localparam int BUS_W  = NPORTS * LINK_W;

    typedef enum logic [SEL_W-1:0] {
        PORT_N = 3'd0,
        PORT_S = 3'd1,
        PORT_E = 3'd2,
        PORT_W = 3'd3,
        PORT_L = 3'd4
    } port_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] src;
    } route_cfg_t;

    function automatic logic cfg_usable(route_cfg_t c);
        return c.en && (int'(c.src) < NPORTS);
    endfunction
endpackage

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
    import mesh_route_pkg::*;
#(
    parameter int NP = NPORTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SEL_W-1:0]     port,
    input  logic [CFG_W-1:0]     val,
    output route_cfg_t [NP-1:0]  cfg_q
);
    for (genvar p = 0; p < NP; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[p] <= '0;
            else if (we && port == SEL_W'(p))
                cfg_q[p] <= route_cfg_t'(val);
        end

        // R3: an addressed write lands at the next edge
        a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
            (we && port == SEL_W'(p)) |=> (cfg_q[p] == route_cfg_t'($past(val))));
    end

    // R8: writes to a nonexistent port leave the table untouched
    a_r8_bad_port_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && int'(port) >= NP) |=> $stable(cfg_q));

    // R10: no write means no entry change
    a_r10_table_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/route_xpoint.sv
module route_xpoint
    import mesh_route_pkg::*;
#(
    parameter int NP = NPORTS,
    parameter int W  = LINK_W
) (
    input  logic [NP*W-1:0] in_bus,
    input  route_cfg_t      cfg,
    output logic [W-1:0]    sel_data,
    output logic            sel_ok
);
    logic [NP-1:0] xp_en;

    for (genvar i = 0; i < NP; i++) begin : g_en
        assign xp_en[i] = cfg.en && (cfg.src == SEL_W'(i));
    end

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NP; i++)
            sel_data = sel_data | (in_bus[i*W +: W] & {W{xp_en[i]}});
        sel_ok = |xp_en;
    end

    // R2: at most one crosspoint on a given output is closed
    always_comb begin
        a_r2_single_source: assert ($onehot0(xp_en));
    end
endmodule

// File: rtl/route_out_stage.sv
module route_out_stage
    import mesh_route_pkg::*;
#(
    parameter int W = LINK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic         ok,
    output logic [W-1:0] q,
    output logic         vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            q   <= ok ? d : '0;
            vld <= ok;
        end
    end

    // R6: an idle output carries zeros
    a_r6_idle_is_zero: assert property (@(posedge clk) disable iff (rst)
        !vld |-> (q == '0));
endmodule

// File: rtl/mesh_route_switch.sv
module mesh_route_switch
    import mesh_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_port,
    input  logic [3:0]       cfg_val,
    input  logic [39:0]      in_bus,
    output logic [39:0]      out_bus,
    output logic [4:0]       out_vld
);
    route_cfg_t [NPORTS-1:0] cfg_q;
    logic [LINK_W-1:0]       in_words [NPORTS];

    route_cfg_regs #(.NP(NPORTS)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .port (cfg_port),
        .val  (cfg_val),
        .cfg_q(cfg_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [LINK_W-1:0] xp_data;
        logic              xp_ok;

        assign in_words[p] = in_bus[p*LINK_W +: LINK_W];

        route_xpoint #(.NP(NPORTS), .W(LINK_W)) u_xp (
            .in_bus  (in_bus),
            .cfg     (cfg_q[p]),
            .sel_data(xp_data),
            .sel_ok  (xp_ok)
        );

        route_out_stage #(.W(LINK_W)) u_out (
            .clk(clk),
            .rst(rst),
            .d  (xp_data),
            .ok (xp_ok),
            .q  (out_bus[p*LINK_W +: LINK_W]),
            .vld(out_vld[p])
        );

        // R2: a usable entry forwards the chosen input after one clock
        a_r2_one_hop: assert property (@(posedge clk) disable iff (rst)
            cfg_usable(cfg_q[p]) |=>
                (out_vld[p] && out_bus[p*LINK_W +: LINK_W] == $past(in_words[cfg_q[p].src])));

        // R7: an out-of-range source never raises valid
        a_r7_bad_src_idle: assert property (@(posedge clk) disable iff (rst)
            !cfg_usable(cfg_q[p]) |=> !out_vld[p]);
    end
endmodule

// File: tb/tb_mesh_route_switch.sv
`timescale 1ns/1ps
module tb_mesh_route_switch;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_port;
    logic [3:0]  cfg_val;
    logic [39:0] in_bus;
    logic [39:0] out_bus;
    logic [4:0]  out_vld;

    int total = 0;
    int bad   = 0;

    logic       m_en  [5];
    logic [2:0] m_src [5];

    always #2 clk = ~clk;

    mesh_route_switch dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_val(cfg_val), .in_bus(in_bus), .out_bus(out_bus), .out_vld(out_vld)
    );

    function automatic logic exp_vld(int p);
        return m_en[p] && (m_src[p] < 3'd5);
    endfunction

    function automatic logic [7:0] exp_word(int p, logic [39:0] ib);
        if (!exp_vld(p)) return 8'h00;
        return ib[m_src[p]*8 +: 8];
    endfunction

    task automatic check_ports(string tag, logic [39:0] ib);
        for (int p = 0; p < 5; p++) begin
            logic [7:0] ew;
            logic       ev;
            ew = exp_word(p, ib);
            ev = exp_vld(p);
            total++;
            if (out_bus[p*8 +: 8] !== ew || out_vld[p] !== ev) begin
                bad++;
                $display("FAIL %s port %0d data act=%h exp=%h vld act=%b exp=%b",
                         tag, p, out_bus[p*8 +: 8], ew, out_vld[p], ev);
            end
        end
    endtask

    // drive one cycle, check outputs after the edge, then advance the model
    task automatic cyc(logic we, logic [2:0] port, logic [3:0] val,
                       logic [39:0] ib, string tag);
        @(negedge clk);
        cfg_we = we; cfg_port = port; cfg_val = val; in_bus = ib;
        @(posedge clk);
        #1;
        check_ports(tag, ib);
        if (we && port < 3'd5) begin
            m_en[port]  = val[3];
            m_src[port] = val[2:0];
        end
    endtask

    task automatic clear_model();
        for (int p = 0; p < 5; p++) begin
            m_en[p] = 1'b0; m_src[p] = 3'd0;
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        rst = 1'b1; cfg_we = 1'b0; cfg_port = '0; cfg_val = '0; in_bus = '0;
        clear_model();
        repeat (3) @(posedge clk);
        #1;
        check_ports("R9 outputs in reset", 40'h0);
        @(negedge clk);
        rst = 1'b0;

        // R9: after reset all entries disabled, random data must not leak
        cyc(1'b0, 3'd0, 4'd0, 40'hA1B2C3D4E5, "R9 reset state");

        // R1 / R3: route north from east, then check the port packing
        cyc(1'b1, 3'd0, 4'b1010, 40'h1122334455, "R3 write cycle");
        cyc(1'b0, 3'd0, 4'd0,    40'h5566778899, "R1 R3 north takes east");

        // R4: local loopback
        cyc(1'b1, 3'd4, 4'b1100, 40'hAB00000000, "R4 write loopback");
        cyc(1'b0, 3'd0, 4'd0,    40'hCD01020304, "R4 loopback");

        // R5: south, east, west all take west input
        cyc(1'b1, 3'd1, 4'b1011, 40'h0, "R5 setup");
        cyc(1'b1, 3'd2, 4'b1011, 40'h0, "R5 setup");
        cyc(1'b1, 3'd3, 4'b1011, 40'h0, "R5 setup");
        cyc(1'b0, 3'd0, 4'd0, 40'h0F1E2D3C4B, "R5 broadcast");

        // R7: enabled with source 6 behaves as disabled
        cyc(1'b1, 3'd2, 4'b1110, 40'hFFFFFFFFFF, "R7 write bad src");
        cyc(1'b0, 3'd0, 4'd0,    40'hFFFFFFFFFF, "R7 bad src idle");

        // R6: clear enable on north
        cyc(1'b1, 3'd0, 4'b0010, 40'h7777777777, "R6 write disable");
        cyc(1'b0, 3'd0, 4'd0,    40'h7777777777, "R6 disabled zero");

        // R8: writes to ports 5..7 change nothing
        cyc(1'b1, 3'd5, 4'b1000, 40'h1234567890, "R8 port5 write");
        cyc(1'b1, 3'd7, 4'b1001, 40'h0987654321, "R8 port7 write");
        cyc(1'b0, 3'd0, 4'd0,    40'hDEADBEEF01, "R8 table unchanged");

        // R10: long quiet run, table must hold while data varies
        for (int i = 0; i < 200; i++)
            cyc(1'b0, 3'($urandom), 4'($urandom), {$urandom, 8'($urandom)}, "R10 hold");

        // R2: random mix of writes and data
        for (int i = 0; i < 3000; i++) begin
            logic we;
            we = ($urandom % 4) == 0;
            cyc(we, 3'($urandom), 4'($urandom), {$urandom, 8'($urandom)}, "R2 random");
        end

        // R9: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        clear_model();
        check_ports("R9 mid-run reset", 40'h0);
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b0, 3'd0, 4'd0, 40'h55AA55AA55, "R9 after mid reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule